// File: doc/BRIEF.md
# Non-Restoring Signed Divider

This unit divides a signed dividend of twice the data width, presented as an upper and a lower half, by a signed divisor of the data width. It returns a signed quotient and a signed remainder of the data width. It also returns four condition flags: negative, zero, overflow and carry. The work is done one quotient bit per clock. The unit takes the magnitude of each operand, then runs a non-restoring loop: the partial remainder is shifted left, and its sign alone decides whether the divisor magnitude is added or subtracted. A single fix-up cycle repairs a negative final remainder and applies the operand signs.

A caller presents the operands, pulses `start` while `busy` is low, and reads the results in the cycle where `done` is high. The results stay on the outputs until the next successful division. Two exception paths leave the results untouched and report through the flags instead: a zero divisor, and a quotient that does not fit the data width.

Top module: `sdiv_nr`

## Requirements
- R1: For a nonzero divisor and a quotient that fits in W signed bits, `quo` equals the dividend divided by the divisor, truncated toward zero. `rem` equals the dividend minus quo times divisor, so it carries the dividend's sign and its magnitude is below the divisor's.
- R2: A zero divisor gives flags N=0, Z=0, V=1, C=1 and leaves `quo` and `rem` at their previous values. `done` rises on the first clock after the accepting edge, and `busy` is never raised.
- R3: When the true quotient lies outside the W-bit signed range, the flags are N=0, Z=0, V=1, C=0 and `quo` and `rem` keep their previous values. One such case is the most negative dividend divided by -1.
- R4: On a normal finish, N equals bit W-1 of `quo`, Z is 1 exactly when `quo` is zero, and V and C are 0.
- R5: For a nonzero divisor, `busy` is high from the accepting edge until `done`. `done` is high for exactly one cycle, and it is set by the W+1-th clock edge after the edge that accepted `start`.
- R6: A `start` pulse while `busy` is high is ignored. The running division finishes with its own operands, its own timing and its own result, and no second operation follows it.
- R7: While reset is applied, `busy`, `done`, `quo`, `rem` and all four flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a division; sampled only while idle |
| dvd_hi | input | W | Upper half of the signed dividend |
| dvd_lo | input | W | Lower half of the signed dividend |
| dvs | input | W | Signed divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quo | output | W | Signed quotient |
| rem | output | W | Signed remainder |
| flag_n | output | 1 | Quotient negative |
| flag_z | output | 1 | Quotient zero |
| flag_v | output | 1 | Overflow or zero divisor |
| flag_c | output | 1 | Zero divisor |

## Verification
Each wrong internal state has its own symptom at the ports:
- A wrong add/subtract choice or a lost shift bit in the loop shows up in `quo` or `rem` in the same cycle `done` rises. It appears as a quotient off by a power of two or a remainder outside the divisor's range.
- A miscounted step counter moves the `done` edge away from W+1 edges, and the bench measures that gap directly.
- A flipped sign correction or overflow limit shows only on operand pairs with mixed signs or at the edge of the quotient range.

The sweep therefore visits every dividend and divisor pair of a 4-bit configuration, so each of these symptoms appears on at least one operation.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } sdiv_state_e;
endpackage

// File: rtl/sdiv_prep.sv
// Operand conditioning: magnitudes, divisor-zero detect, early overflow.
module sdiv_prep #(
  parameter int W = 16
) (
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   lo,
  input  logic [W-1:0]   dvs,
  output logic [2*W-1:0] mag_a,
  output logic [W-1:0]   mag_d,
  output logic           sign_a,
  output logic           sign_d,
  output logic           dvs_zero,
  output logic           ovf_early
);
  localparam logic [2*W-1:0] ONE2 = {{(2*W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0]   ONE1 = {{(W-1){1'b0}}, 1'b1};

  logic [2*W-1:0] full;

  always_comb begin
    full      = {hi, lo};
    sign_a    = hi[W-1];
    sign_d    = dvs[W-1];
    mag_a     = sign_a ? (~full) + ONE2 : full;
    mag_d     = sign_d ? (~dvs) + ONE1 : dvs;
    dvs_zero  = (dvs == '0);
    // Upper half not below divisor: unsigned quotient needs more than W bits.
    ovf_early = (mag_a[2*W-1:W] >= mag_d);
  end
endmodule

// File: rtl/sdiv_step.sv
// One non-restoring iteration on the partial remainder.
module sdiv_step #(
  parameter int W = 16
) (
  input  logic [W+1:0] p_in,
  input  logic [W-1:0] q_in,
  input  logic [W-1:0] dm,
  output logic [W+1:0] p_out,
  output logic [W-1:0] q_out
);
  localparam int PW = W + 2;

  logic [PW-1:0] shifted;
  logic [PW-1:0] dext;

  always_comb begin
    shifted = {p_in[PW-2:0], q_in[W-1]};
    dext    = {2'b00, dm};
    if (!p_in[PW-1]) p_out = shifted - dext;
    else             p_out = shifted + dext;
    q_out = {q_in[W-2:0], ~p_out[PW-1]};
  end
endmodule

// File: rtl/sdiv_fixup.sv
// Final remainder repair, sign application and range check.
module sdiv_fixup #(
  parameter int W = 16
) (
  input  logic [W+1:0] p,
  input  logic [W-1:0] qu,
  input  logic [W-1:0] dm,
  input  logic         sign_a,
  input  logic         sign_d,
  input  logic         ovf_early,
  output logic [W+1:0] rem_mag,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         ovf
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE1 = {{(W-1){1'b0}}, 1'b1};

  logic neg;

  always_comb begin
    rem_mag = p[W+1] ? p + {2'b00, dm} : p;
    neg     = sign_a ^ sign_d;
    ovf     = ovf_early | (neg ? (qu > HALF) : qu[W-1]);
    quo     = neg ? (~qu) + ONE1 : qu;
    rem     = sign_a ? (~rem_mag[W-1:0]) + ONE1 : rem_mag[W-1:0];
  end
endmodule

// File: rtl/sdiv_nr.sv
module sdiv_nr
  import sdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvs,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c
);
  localparam int PW = W + 2;
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(W - 1);

  // Reset: asynchronous assertion, synchronous release.
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sdiv_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_dec;
  logic [PW-1:0] p_q, p_d;
  logic [W-1:0]  sh_q, sh_d, dm_q, dm_d;
  logic          sa_q, sa_d, sd_q, sd_d, ovf_q, ovf_d;
  logic [W-1:0]  quo_q, quo_d, rem_q, rem_d;
  logic [3:0]    flg_q, flg_d;  // {N, Z, V, C}
  logic          done_q, done_d;
  logic          dp_en, res_en;

  logic [2*W-1:0] mag_a;
  logic [W-1:0]   mag_d;
  logic           sign_a, sign_d, dvs_zero, ovf_early;

  sdiv_prep #(.W(W)) u_prep (
    .hi(dvd_hi), .lo(dvd_lo), .dvs(dvs),
    .mag_a(mag_a), .mag_d(mag_d), .sign_a(sign_a), .sign_d(sign_d),
    .dvs_zero(dvs_zero), .ovf_early(ovf_early)
  );

  logic [PW-1:0] p_step;
  logic [W-1:0]  q_step;

  sdiv_step #(.W(W)) u_step (
    .p_in(p_q), .q_in(sh_q), .dm(dm_q), .p_out(p_step), .q_out(q_step)
  );

  logic [PW-1:0] rem_mag;
  logic [W-1:0]  fx_quo, fx_rem;
  logic          fx_ovf;

  sdiv_fixup #(.W(W)) u_fix (
    .p(p_q), .qu(sh_q), .dm(dm_q), .sign_a(sa_q), .sign_d(sd_q),
    .ovf_early(ovf_q), .rem_mag(rem_mag), .quo(fx_quo), .rem(fx_rem),
    .ovf(fx_ovf)
  );

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    cnt_dec = cnt_q - 1'b1;
    cnt_d   = cnt_q;
    p_d     = p_q;
    sh_d    = sh_q;
    dm_d    = dm_q;
    sa_d    = sa_q;
    sd_d    = sd_q;
    ovf_d   = ovf_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    flg_d   = flg_q;
    done_d  = 1'b0;
    dp_en   = 1'b0;
    res_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (dvs_zero) begin
            flg_d  = 4'b0011;
            done_d = 1'b1;
            res_en = 1'b1;
          end else begin
            dp_en   = 1'b1;
            p_d     = {2'b00, mag_a[2*W-1:W]};
            sh_d    = mag_a[W-1:0];
            dm_d    = mag_d;
            sa_d    = sign_a;
            sd_d    = sign_d;
            ovf_d   = ovf_early;
            cnt_d   = CNT_INIT;
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        dp_en = 1'b1;
        p_d   = p_step;
        sh_d  = q_step;
        cnt_d = cnt_dec;
        if (cnt_dec[CW-1]) state_d = ST_FIX;
      end
      ST_FIX: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        res_en  = 1'b1;
        if (fx_ovf) begin
          flg_d = 4'b0010;
        end else begin
          quo_d = fx_quo;
          rem_d = fx_rem;
          flg_d = {fx_quo[W-1], (fx_quo == '0), 2'b00};
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      p_q     <= '0;
      sh_q    <= '0;
      dm_q    <= '0;
      sa_q    <= 1'b0;
      sd_q    <= 1'b0;
      ovf_q   <= 1'b0;
      quo_q   <= '0;
      rem_q   <= '0;
      flg_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (dp_en) begin
        cnt_q <= cnt_d;
        p_q   <= p_d;
        sh_q  <= sh_d;
        dm_q  <= dm_d;
        sa_q  <= sa_d;
        sd_q  <= sd_d;
        ovf_q <= ovf_d;
      end
      if (res_en) begin
        quo_q <= quo_d;
        rem_q <= rem_d;
        flg_q <= flg_d;
      end
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign quo    = quo_q;
  assign rem    = rem_q;
  assign flag_n = flg_q[3];
  assign flag_z = flg_q[2];
  assign flag_v = flg_q[1];
  assign flag_c = flg_q[0];

  // R1: repaired remainder magnitude stays below the divisor magnitude.
  a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_FIX && !ovf_q) |-> (rem_mag < {2'b00, dm_q}));

  // R2: zero divisor flags and held results on the next cycle.
  a_r2_zero_div: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_IDLE && start && dvs == '0) |=>
      (done && flag_v && flag_c && !busy && $stable(quo_q) && $stable(rem_q)));

  // R3: overflow finish leaves the result registers untouched.
  a_r3_ovf_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && flag_v && !flag_c) |-> ($stable(quo_q) && $stable(rem_q) && !flag_n && !flag_z));

  // R4: flags agree with the stored quotient on a normal finish.
  a_r4_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !flag_v) |-> (!flag_c && (flag_z == (quo == '0)) && (flag_n == quo[W-1])));

  // R5: done is a single-cycle pulse and never overlaps busy.
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> !busy);

  // R6: a start while busy does not reload the divisor.
  a_r6_ignore_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && start) |=> $stable(dm_q));
endmodule

// File: tb/sdiv_nr_bench.sv
module sdiv_nr_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dvd_hi = '0, dvd_lo = '0, dvs = '0;
  logic         busy, done, flag_n, flag_z, flag_v, flag_c;
  logic [W-1:0] quo, rem;

  int compared = 0;
  int mismatched = 0;
  logic [W-1:0] held_q = '0, held_r = '0;

  always #10 clk = ~clk;  // 50 MHz

  sdiv_nr #(.W(W)) u_sdiv_nr (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
    .busy(busy), .done(done), .quo(quo), .rem(rem),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int a, input int d, input bit poke);
    logic [2*W-1:0] av;
    int lat, q, r, exp_lat;
    bit saw_busy_drop;
    av = a[2*W-1:0];
    @(negedge clk);
    dvd_hi = av[2*W-1:W];
    dvd_lo = av[W-1:0];
    dvs    = d[W-1:0];
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    saw_busy_drop = 0;
    while (!done && lat < 60) begin
      if (!busy) saw_busy_drop = 1;
      if (poke && lat == 1) begin
        dvd_hi = ~dvd_hi; dvd_lo = ~dvd_lo; dvs = dvs + 1'b1; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    exp_lat = (d == 0) ? 0 : W + 1;
    check(lat == exp_lat, "R5 latency", lat, exp_lat);
    if (d != 0) check(!saw_busy_drop, "R5 busy held", saw_busy_drop, 0);
    if (d == 0) begin
      check({flag_n, flag_z, flag_v, flag_c} == 4'b0011, "R2 flags",
            {flag_n, flag_z, flag_v, flag_c}, 3);
      check(quo == held_q && rem == held_r, "R2 results held",
            {quo, rem}, {held_q, held_r});
    end else begin
      q = a / d;  // truncates toward zero
      r = a % d;  // sign of dividend
      if (q > (2 ** (W - 1)) - 1 || q < -(2 ** (W - 1))) begin
        // R3: includes the most negative dividend over -1
        check({flag_n, flag_z, flag_v, flag_c} == 4'b0010, "R3 flags",
              {flag_n, flag_z, flag_v, flag_c}, 2);
        check(quo == held_q && rem == held_r, "R3 results held",
              {quo, rem}, {held_q, held_r});
      end else begin
        check(quo == q[W-1:0], "R1 quotient", quo, q[W-1:0]);
        check(rem == r[W-1:0], "R1 remainder", rem, r[W-1:0]);
        check({flag_n, flag_z, flag_v, flag_c} == {q < 0, q == 0, 2'b00}, "R4 flags",
              {flag_n, flag_z, flag_v, flag_c}, {q < 0, q == 0, 2'b00});
        held_q = q[W-1:0];
        held_r = r[W-1:0];
      end
    end
    @(negedge clk);
    check(!done, "R5 done single cycle", done, 0);
    if (poke) check(!busy, "R6 no second operation", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check({busy, done, quo, rem, flag_n, flag_z, flag_v, flag_c} == '0, "R7 reset",
          {busy, done, quo, rem, flag_n, flag_z, flag_v, flag_c}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = -(2 ** (2 * W - 1)); a < 2 ** (2 * W - 1); a++)
      for (int d = -(2 ** (W - 1)); d < 2 ** (W - 1); d++)
        run_op(a, d, 1'b0);
    // R6: restart attempts during a running division
    run_op(100, 3, 1'b1);
    run_op(-77, 5, 1'b1);
    run_op(-128, -1, 1'b1);
    run_op(-9, -2, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule